// File: doc/BRIEF.md
# TDC Time Histogram Builder

This block collects the distribution of 4-bit fine-time codes coming from a time-to-digital converter for a single channel. Each valid hit adds one to the bin selected by its code, so the sixteen bins together show where hits fall inside the machine cycle. A new hit can be taken on every clock cycle with no dead time.

Each bin is a counter of parameterised width, 24 bits by default. When the first bin reaches its largest value, the whole histogram freezes. This keeps the ratios between bins intact. A status flag reports the freeze and a field records which bin got there first. A clear command empties all bins and restarts collection. Bin contents can be read at any time through a combinational read port, and reading does not disturb counting.

Top module: `tdc_hist`

## Requirements
- R1: After reset every bin reads zero, `frozen` is 0 and `sat_bin` is 0.
- R2: A cycle with `hit_valid` high, `clear` low and the histogram not frozen adds exactly one to the bin whose index equals `hit_code`. All other bins are left unchanged, and the new value is readable after that clock edge.
- R3: Hits on consecutive cycles are each counted, with no cycle lost.
- R4: A cycle with `hit_valid` low and `clear` low changes no bin and no status.
- R5: The hit that brings a bin to 2^CNT_W-1 is counted, and at the same clock edge `frozen` rises and `sat_bin` takes that bin's index.
- R6: While `frozen` is 1 and `clear` is low, hits change no bin, and `sat_bin` holds its value.
- R7: A cycle with `clear` high sets all bins to zero, drops `frozen` and zeroes `sat_bin`. A hit in the same cycle is not counted.
- R8: `rd_data` always shows the current count of bin `rd_addr`, and changing `rd_addr` while hits arrive does not alter any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is present this cycle |
| hit_code | input | 4 | TDC fine-time code of the hit, used as the bin index |
| clear | input | 1 | Empty all bins and remove the freeze |
| rd_addr | input | 4 | Index of the bin to read |
| rd_data | output | CNT_W | Count of the selected bin |
| frozen | output | 1 | A bin has saturated and counting has stopped |
| sat_bin | output | 4 | Index of the bin that saturated first |

## Verification
The bench uses narrow 5-bit bins so it can drive saturation on more than one code within its run. The first saturation exposes a design that wraps a bin to zero or freezes one hit late: that design would read 0 or 31 at the wrong moment, or would count one hit past the limit. Hits sent while frozen show whether the freeze is global. A per-bin stop would let the other bins keep rising. A hit sent together with a clear exposes a design that lets the hit through, because it would leave a count of 1 in that bin. Long back-to-back streams on mixed codes, read out while the read address moves, catch dropped hits and any read that disturbs counting.

// File: rtl/tdc_hist.sv
module tdc_hist #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_valid,
  input  logic [CODE_W-1:0] hit_code,
  input  logic              clear,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              frozen,
  output logic [CODE_W-1:0] sat_bin
);
  localparam int NBINS = 1 << CODE_W;
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [NBINS-1:0][CNT_W-1:0] cnt;
  logic                        take;
  logic                        hits_top;

  assign take     = hit_valid && !frozen && !clear;
  assign hits_top = (cnt[hit_code] == TOP - 1'b1);
  assign rd_data  = cnt[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt     <= '0;
      frozen  <= 1'b0;
      sat_bin <= '0;
    end else if (take) begin
      cnt[hit_code] <= cnt[hit_code] + 1'b1;
      if (hits_top) begin
        frozen  <= 1'b1;
        sat_bin <= hit_code;
      end
    end
  end
endmodule

module tdc_hist_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 24
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 hit_valid,
  input logic [CODE_W-1:0]                    hit_code,
  input logic                                 clear,
  input logic                                 frozen,
  input logic [CODE_W-1:0]                    sat_bin,
  input logic [(1<<CODE_W)-1:0][CNT_W-1:0]    cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !hit_valid |=> $stable(cnt) && $stable(frozen));

  a_r5_freeze_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !frozen && hit_valid && cnt[hit_code] == TOP - 1'b1
      |=> frozen && sat_bin == $past(hit_code));

  a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !clear |=> frozen && $stable(cnt) && $stable(sat_bin));

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !frozen && cnt == '0 && sat_bin == '0);

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !frozen && hit_valid
      |=> cnt[$past(hit_code)] == $past(cnt[hit_code]) + 1'b1);
endmodule

bind tdc_hist tdc_hist_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_code(hit_code),
  .clear(clear), .frozen(frozen), .sat_bin(sat_bin), .cnt(cnt)
);

// File: tb/tdc_hist_tb.sv
module tdc_hist_tb;
  localparam int CW  = 4;
  localparam int NW  = 5;
  localparam int NB  = 16;
  localparam int TOP = (1 << NW) - 1;

  logic clk = 0, rst_n = 0, hit_valid = 0, clear = 0;
  logic [CW-1:0] hit_code = 0, rd_addr = 0;
  logic [NW-1:0] rd_data;
  logic frozen;
  logic [CW-1:0] sat_bin;

  int exp_cnt [NB];
  bit exp_fz;
  int exp_sat;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tdc_hist #(.CODE_W(CW), .CNT_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_code(hit_code),
    .clear(clear), .rd_addr(rd_addr), .rd_data(rd_data),
    .frozen(frozen), .sat_bin(sat_bin));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_zero();
    for (int i = 0; i < NB; i++) exp_cnt[i] = 0;
    exp_fz = 0; exp_sat = 0;
  endtask

  // one clock with the given inputs, model updated after the edge
  task automatic cyc(input bit v, input int c, input bit cl);
    hit_valid = v; hit_code = c[CW-1:0]; clear = cl;
    @(posedge clk);
    if (cl) model_zero();
    else if (v && !exp_fz) begin
      exp_cnt[c]++;
      if (exp_cnt[c] == TOP) begin exp_fz = 1; exp_sat = c; end
    end
    #2;
  endtask

  task automatic check_all(input string req);
    hit_valid = 0; clear = 0;
    for (int a = 0; a < NB; a++) begin
      rd_addr = a[CW-1:0]; #1;
      chk(req, int'(rd_data), exp_cnt[a]);
    end
    chk(req, int'(frozen), int'(exp_fz));
    chk(req, int'(sat_bin), exp_sat);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_zero();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    check_all("R1");

    // R3: every code once, back to back
    for (int i = 0; i < NB; i++) cyc(1, i, 0);
    check_all("R3");

    // R4: idle cycles change nothing
    for (int i = 0; i < 5; i++) cyc(0, i, 0);
    check_all("R4");

    // R2/R8: mixed pattern, read address following the hit code
    for (int i = 0; i < 120; i++) begin
      rd_addr = ((i * 7 + 3) % NB);
      cyc((i % 3) != 0, (i * 7 + 3) % NB, 0);
      chk("R8", int'(rd_data), exp_cnt[(i * 7 + 3) % NB]);
    end
    check_all("R2");

    // R5: drive code 9 up to saturation
    while (!exp_fz) cyc(1, 9, 0);
    check_all("R5");
    chk("R5", exp_sat, 9);

    // R6: hits while frozen are dropped
    for (int i = 0; i < 40; i++) cyc(1, i % NB, 0);
    check_all("R6");

    // R7: clear with a simultaneous hit
    cyc(1, 4, 1);
    check_all("R7");

    // second saturation on another code after clear, then sweep to catch early freeze
    for (int i = 0; i < TOP - 1; i++) cyc(1, 14, 0);
    check_all("R5");
    cyc(1, 2, 0);
    cyc(1, 14, 0);
    check_all("R5");
    chk("R5", int'(sat_bin), 14);

    cyc(0, 0, 1);
    check_all("R7");
    finish_run();
  end
endmodule